// File: doc/BRIEF.md
# Reference Track-and-Hold State Controller

This block is the control state machine of a redundant timing card. It watches validity flags for two reference inputs, a flag that reports a phase error larger than a quarter bit, a test pushbutton, a TEST/RUN strap and a one-second tick. From these it decides whether the card runs free, acquires a reference in two phases, tracks it, holds over, or runs standalone. It drives a status LED vector, a single-character status code for a seven-segment display, and the correction word that goes to the synthesizer.

While the card tracks, the controller passes the loop's correction word through to the output. In the locked state it also keeps an exponential moving average of that word. In holdover it drives that average in place of a frozen value, so the correction seen before the reference was lost keeps compensating oscillator aging. The test button has a different meaning in each state. In a tracking state it starts a momentary holdover test that leaves tracking undisturbed. In free run or holdover it restarts qualification from free run.

Top module: `ref_holdover_ctrl`

## Requirements
- R1: After reset the state is free run (code 0), `corr_out` is 0, `disp` is 'r' (0x72) and `leds` is 0x0C0 (FREERUN and ACTIVE only).
- R2: While `test_strap` is 1 the state becomes standalone (code 5) on the next edge, `leds` is 0x001, `disp` is 'S' (0x53) and `corr_out` is 0. One edge after the strap is released the state is free run.
- R3: In free run (0) or holdover (4), a tick during which `valid_a` or `valid_b` is high advances a qualification count. A cycle with both inputs low clears the count. The QUAL_TICKS-th such tick moves the state to ACQUIRE 1 (code 1) and selects input B (`sel_b`=1) only if `valid_a` is low at that edge.
- R4: ACQUIRE 1 moves to ACQUIRE 2 (code 2) on its ACQ1_TICKS-th tick. ACQUIRE 2 moves to locked (code 3) on the ACQ2_TICKS-th tick with no phase error. Any cycle with `phase_big` high in ACQUIRE 2 restarts that count.
- R5: In the locked state, `phase_big` moves the state to ACQUIRE 2 on the next edge. The DEGRADED LED (bit 8) then stays lit until the state leaves ACQUIRE 2.
- R6: In states 1, 2 or 3, a low validity flag on the selected input moves the state to holdover (4) on the next edge. This takes priority over a test button press in the same cycle.
- R7: A rising edge of `test_btn` in states 1, 2 or 3 with the selected input valid leaves the state path unchanged. Until the next tick, it lights the HOLD LED, shows 'H' (0x48) and drives the averaged correction on `corr_out`.
- R8: A rising edge of `test_btn` in free run or holdover puts the state into free run with the qualification count cleared.
- R9: The accumulator is updated only on a tick in the locked state, as acc = acc + corr_in - (acc >>> AVG_SHIFT). The average is acc >>> AVG_SHIFT.
- R10: `corr_out` is the average in holdover or during a hold test, `corr_in` in states 1 to 3 otherwise, and 0 in states 0 and 5.
- R11: `disp` shows 'h' (0x68) in holdover and '.' (0x2E) in ACQUIRE 1. In ACQUIRE 2 and locked it shows '_' (0x5F) when `phase_big` is high and '^' (0x5E) otherwise. In states 1 to 3, every tick toggles a blank phase that shows ' ' (0x20).
- R12: `leds` bits are: 0 FAIL (standalone), 1 INPUT A, 2 INPUT B (each only in states 1 to 3), 3 HOLD, 4 ACQUIRE (states 1 and 2), 5 LOCKED, 6 FREERUN, 7 ACTIVE (any state but 5), 8 DEGRADED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_a | input | 1 | Reference A is good |
| valid_b | input | 1 | Reference B is good |
| phase_big | input | 1 | Phase moved by more than a quarter bit |
| test_btn | input | 1 | Test pushbutton level |
| test_strap | input | 1 | 1 = TEST position, forces standalone |
| tick | input | 1 | One-second strobe, one cycle wide |
| corr_in | input | CW | Signed correction word from the loop |
| state | output | 3 | Current state code |
| sel_b | output | 1 | Selected input is B |
| active | output | 1 | Card drives the outputs |
| leds | output | 9 | Status LED vector |
| disp | output | 8 | Status character, ASCII |
| corr_out | output | CW | Correction applied to the synthesizer |

## Verification
The hold test and the loss of the selected input can land on the same edge. The bench provokes this with a directed step that raises `test_btn` and drops `valid_a` together while locked. The expected result is holdover showing 'h', never 'H'. Random stimulus also makes button edges coincide with ticks, phase errors and strap pulses. Every cycle is judged against a bench-side model of the state, LED, display and correction outputs.

// File: rtl/ref_holdover_ctrl.sv
`timescale 1ns/1ps
module ref_holdover_ctrl #(
  parameter int CW         = 16,
  parameter int AVG_SHIFT  = 3,
  parameter int QUAL_TICKS = 4,
  parameter int ACQ1_TICKS = 3,
  parameter int ACQ2_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_a,
  input  logic          valid_b,
  input  logic          phase_big,
  input  logic          test_btn,
  input  logic          test_strap,
  input  logic          tick,
  input  logic [CW-1:0] corr_in,
  output logic [2:0]    state,
  output logic          sel_b,
  output logic          active,
  output logic [8:0]    leds,
  output logic [7:0]    disp,
  output logic [CW-1:0] corr_out
);
  localparam int MAXT1 = (QUAL_TICKS > ACQ1_TICKS) ? QUAL_TICKS : ACQ1_TICKS;
  localparam int MAXT  = (MAXT1 > ACQ2_TICKS) ? MAXT1 : ACQ2_TICKS;
  localparam int CNTW  = $clog2(MAXT + 1);
  localparam int AW    = CW + AVG_SHIFT + 1;

  typedef enum logic [2:0] {
    ST_FREE = 3'd0, ST_ACQ1 = 3'd1, ST_ACQ2 = 3'd2,
    ST_LOCK = 3'd3, ST_HOLD = 3'd4, ST_SOLO = 3'd5
  } st_t;

  st_t st, st_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic sel_q, sel_n, blink, htest, degr, btn_q;
  logic signed [AW-1:0] acc;

  wire trk    = (st == ST_ACQ1) || (st == ST_ACQ2) || (st == ST_LOCK);
  wire trk_n  = (st_n == ST_ACQ1) || (st_n == ST_ACQ2) || (st_n == ST_LOCK);
  wire any_ok = valid_a | valid_b;
  wire sel_ok = sel_q ? valid_b : valid_a;
  wire press  = test_btn & ~btn_q;
  wire signed [AW-1:0] cext = {{(AW-CW){corr_in[CW-1]}}, corr_in};

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    sel_n = sel_q;
    if (test_strap) begin
      st_n  = ST_SOLO;
      cnt_n = '0;
    end else begin
      case (st)
        ST_SOLO: begin st_n = ST_FREE; cnt_n = '0; end
        ST_FREE, ST_HOLD: begin
          if (press) begin
            st_n  = ST_FREE;
            cnt_n = '0;
          end else if (!any_ok) cnt_n = '0;
          else if (tick) begin
            if (cnt == CNTW'(QUAL_TICKS - 1)) begin
              st_n  = ST_ACQ1;
              cnt_n = '0;
              sel_n = !valid_a;
            end else cnt_n = cnt + 1'b1;
          end
        end
        ST_ACQ1: begin
          if (!sel_ok) begin st_n = ST_HOLD; cnt_n = '0; end
          else if (tick) begin
            if (cnt == CNTW'(ACQ1_TICKS - 1)) begin st_n = ST_ACQ2; cnt_n = '0; end
            else cnt_n = cnt + 1'b1;
          end
        end
        ST_ACQ2: begin
          if (!sel_ok) begin st_n = ST_HOLD; cnt_n = '0; end
          else if (phase_big) cnt_n = '0;
          else if (tick) begin
            if (cnt == CNTW'(ACQ2_TICKS - 1)) begin st_n = ST_LOCK; cnt_n = '0; end
            else cnt_n = cnt + 1'b1;
          end
        end
        ST_LOCK: begin
          if (!sel_ok) begin st_n = ST_HOLD; cnt_n = '0; end
          else if (phase_big) begin st_n = ST_ACQ2; cnt_n = '0; end
        end
        default: begin st_n = ST_FREE; cnt_n = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_FREE;
      cnt   <= '0;
      sel_q <= 1'b0;
      blink <= 1'b0;
      htest <= 1'b0;
      degr  <= 1'b0;
      btn_q <= 1'b0;
      acc   <= '0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      sel_q <= sel_n;
      btn_q <= test_btn;
      blink <= trk ? (blink ^ tick) : 1'b0;
      htest <= trk_n && ((press && trk && sel_ok) || (htest && !tick));
      degr  <= (st_n == ST_ACQ2) && ((st == ST_LOCK) || degr);
      if (st == ST_LOCK && tick) acc <= acc + cext - (acc >>> AVG_SHIFT);
    end
  end

  assign state    = st;
  assign sel_b    = sel_q;
  assign active   = (st != ST_SOLO);
  assign corr_out = (st == ST_HOLD || htest) ? CW'(acc >>> AVG_SHIFT) :
                    trk ? corr_in : '0;
  assign leds = {degr, active, st == ST_FREE, st == ST_LOCK,
                 (st == ST_ACQ1) || (st == ST_ACQ2), (st == ST_HOLD) || htest,
                 trk & sel_q, trk & ~sel_q, st == ST_SOLO};

  always_comb begin
    case (st)
      ST_SOLO: disp = 8'h53;
      ST_FREE: disp = 8'h72;
      ST_HOLD: disp = 8'h68;
      default: begin
        if (htest)            disp = 8'h48;
        else if (blink)       disp = 8'h20;
        else if (st == ST_ACQ1) disp = 8'h2E;
        else if (phase_big)   disp = 8'h5F;
        else                  disp = 8'h5E;
      end
    endcase
  end

  assert_standalone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    test_strap |=> (state == 3'd5 && leds == 9'h001));
  assert_loss_to_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trk && !sel_ok && !test_strap) |=> (state == 3'd4));
  assert_button_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_FREE || st == ST_HOLD) && press && !test_strap) |=> (state == 3'd0 && cnt == '0));
  assert_avg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == ST_LOCK && tick) |=> $stable(acc));
  assert_one_input_led_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(leds[2:1]));
  assert_hold_test_shown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (press && trk && sel_ok && !test_strap) |=> (leds[3] && disp == 8'h48));
endmodule

// File: tb/ref_holdover_ctrl_tb.sv
`timescale 1ns/1ps
module ref_holdover_ctrl_tb;
  localparam int CW = 16, SH = 3, QUAL = 4, ACQ1 = 3, ACQ2 = 4;

  logic clk = 0, rst_n = 0;
  logic va = 0, vb = 0, ph = 0, btn = 0, strap = 0, tk = 0;
  logic [CW-1:0] corr = '0;
  logic [2:0] state;
  logic sel_b, active;
  logic [8:0] leds;
  logic [7:0] disp;
  logic [CW-1:0] corr_out;

  int total = 0, fails = 0;
  int m_st, m_cnt, m_acc;
  bit m_sel, m_blink, m_ht, m_dg, m_bq;

  always #5 clk = ~clk;

  ref_holdover_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .valid_a(va), .valid_b(vb), .phase_big(ph),
    .test_btn(btn), .test_strap(strap), .tick(tk), .corr_in(corr),
    .state(state), .sel_b(sel_b), .active(active), .leds(leds),
    .disp(disp), .corr_out(corr_out));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_sel = 0; m_blink = 0; m_ht = 0; m_dg = 0; m_bq = 0; m_acc = 0;
    end else begin
      int ns, nc;
      bit nsel, trkc, trkn, selok, pr, anyok;
      ns = m_st; nc = m_cnt; nsel = m_sel;
      trkc  = (m_st >= 1 && m_st <= 3);
      selok = m_sel ? vb : va;
      pr    = btn && !m_bq;
      anyok = va || vb;
      if (strap) begin ns = 5; nc = 0; end
      else if (m_st == 5) begin ns = 0; nc = 0; end
      else if (m_st == 0 || m_st == 4) begin
        if (pr) begin ns = 0; nc = 0; end
        else if (!anyok) nc = 0;
        else if (tk) begin
          if (m_cnt == QUAL - 1) begin ns = 1; nc = 0; nsel = !va; end else nc = m_cnt + 1;
        end
      end else if (!selok) begin ns = 4; nc = 0; end
      else if (m_st == 1) begin
        if (tk) begin if (m_cnt == ACQ1 - 1) begin ns = 2; nc = 0; end else nc = m_cnt + 1; end
      end else if (m_st == 2) begin
        if (ph) nc = 0;
        else if (tk) begin if (m_cnt == ACQ2 - 1) begin ns = 3; nc = 0; end else nc = m_cnt + 1; end
      end else if (ph) begin ns = 2; nc = 0; end
      trkn = (ns >= 1 && ns <= 3);
      m_ht = trkn && ((pr && trkc && selok) || (m_ht && !tk));
      m_dg = (ns == 2) && (m_st == 3 || m_dg);
      m_blink = trkc ? (m_blink ^ tk) : 1'b0;
      if (m_st == 3 && tk) m_acc = m_acc + int'($signed(corr)) - (m_acc >>> SH);
      m_bq = btn; m_st = ns; m_cnt = nc; m_sel = nsel;
    end
  end

  function automatic logic [8:0] exp_leds();
    bit t = (m_st >= 1 && m_st <= 3);
    return {m_dg, m_st != 5, m_st == 0, m_st == 3, m_st == 1 || m_st == 2,
            m_st == 4 || m_ht, t && m_sel, t && !m_sel, m_st == 5};
  endfunction

  function automatic logic [7:0] exp_disp();
    if (m_st == 5) return 8'h53;
    if (m_st == 0) return 8'h72;
    if (m_st == 4) return 8'h68;
    if (m_ht) return 8'h48;
    if (m_blink) return 8'h20;
    if (m_st == 1) return 8'h2E;
    return ph ? 8'h5F : 8'h5E;
  endfunction

  function automatic logic [CW-1:0] exp_corr();
    int a = m_acc >>> SH;
    if (m_st == 4 || m_ht) return a[CW-1:0];
    if (m_st >= 1 && m_st <= 3) return corr;
    return '0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_all();
    chk(state == 3'(m_st), "state R2 R3 R4 R5 R6 R8", int'(state), m_st);
    chk(leds == exp_leds(), "leds R12 R5", int'(leds), int'(exp_leds()));
    chk(disp == exp_disp(), "disp R11 R7", int'(disp), int'(exp_disp()));
    chk(corr_out == exp_corr(), "corr R9 R10", int'(corr_out), int'(exp_corr()));
  endtask

  task automatic cyc(input bit a, input bit b, input bit p, input bit bt,
                     input bit s, input bit t, input logic [CW-1:0] c);
    @(negedge clk);
    check_all();
    va = a; vb = b; ph = p; btn = bt; strap = s; tk = t; corr = c;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(state == 3'd0, "R1 state", int'(state), 0);
    chk(leds == 9'h0C0, "R1 leds", int'(leds), 'h0C0);
    chk(disp == 8'h72, "R1 disp", int'(disp), 'h72);
    chk(corr_out == '0, "R1 corr", int'(corr_out), 0);
    rst_n = 1;

    for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0, 0, 1, 16'd800);
    settle();
    chk(state == 3'd3, "R4 locked after acquisition", int'(state), 3);
    chk(sel_b == 1'b0, "R3 input A chosen", int'(sel_b), 0);
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, 1, 16'd800);
    cyc(1, 1, 0, 1, 0, 0, 16'd800);
    settle();
    chk(disp == 8'h48 && state == 3'd3, "R7 hold test", int'(disp), 'h48);
    cyc(1, 1, 0, 0, 0, 1, 16'd800);
    cyc(1, 1, 1, 0, 0, 0, 16'd800);
    settle();
    chk(state == 3'd2 && leds[8], "R5 degraded", int'(state), 2);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 1, 16'd800);
    cyc(0, 1, 0, 1, 0, 0, 16'd800);
    settle();
    chk(state == 3'd4 && disp == 8'h68, "R6 loss beats hold test", int'(disp), 'h68);
    cyc(0, 1, 0, 0, 0, 0, 16'd800);
    cyc(0, 1, 0, 1, 0, 0, 16'd800);
    settle();
    chk(state == 3'd0 && disp == 8'h72, "R8 restart to free run", int'(state), 0);
    cyc(0, 1, 0, 0, 1, 0, 16'd800);
    settle();
    chk(state == 3'd5 && leds == 9'h001, "R2 standalone", int'(leds), 'h001);
    cyc(0, 1, 0, 0, 0, 0, 16'd800);
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, 1, 16'd100);
    settle();
    chk(state == 3'd1 && sel_b, "R3 input B chosen", int'(sel_b), 1);

    for (int i = 0; i < 20000; i++) begin
      bit a = ($urandom % 50) != 0;
      bit b = ($urandom % 30) != 0;
      bit p = ($urandom % 12) == 0;
      bit bt = ($urandom % 20) == 0;
      bit s = ($urandom % 400) == 0;
      bit t = ($urandom % 3) == 0;
      int c = int'($urandom % 2001) - 1000;
      cyc(a, b, p, bt, s, t, CW'(c));
    end
    @(negedge clk);
    check_all();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule